// File: doc/BRIEF.md
# Power-Mode-Gated Control Register Port

This block is the 32-bit control and status register port of a memory module. A CPU drives chip select, write enable, a word address and write data, and holds them steady for a two-cycle access. The block does not latch these inputs. It samples them at the clock edge that closes the second cycle of the access. On that edge it commits the access. It then pulses `ready` for one cycle, and for a read it presents the selected word on `rdata` in the same cycle.

The register set has ten word slots, and each slot's word address is given in the requirements. A low-power-mode input controls what the port allows:
- While low-power mode is high, every write is locked out.
- While low-power mode is high, a designated set of registers reads back as zero. These are five signature registers, two test registers, and the low half of a third test register.
- Outside low-power mode, every register reads live, including while the memory array is busy.

Unmapped addresses read as zero and ignore writes.

Top module: `rau_top`

## Requirements
- R1: After synchronous reset, `ready` is 0, `rdata` is 0, and every register reads 0.
- R2: An access begins on a rising edge where `cs` is 1 and no access is pending. It commits on the next rising edge if `cs` is still 1. `ready` is 1 for exactly the one cycle that follows the commit edge, and 0 in the cycle after that.
- R3: `we`, `addr`, `wdata` and `lp_mode` are taken from the commit edge only. Values present at the first edge of the access have no effect.
- R4: If `cs` is 0 at the commit edge, the access is abandoned. No `ready` pulse follows and no register changes.
- R5: A committed read returns the full 32-bit word at `addr` on `rdata` together with `ready`. Whenever `ready` is 0, and for committed writes, `rdata` is 0.
- R6: A read of an unmapped word address (10 to 15) returns 0.
- R7: A write to an unmapped word address changes no register.
- R8: A write committed with `lp_mode` = 1 changes no register.
- R9: A read committed with `lp_mode` = 1 returns 0 for the signature registers (addresses 5 to 9) and the test registers at addresses 3 and 4.
- R10: A read committed with `lp_mode` = 1 of test register 0 (address 2) returns bits 31:16 live and bits 15:0 as zero.
- R11: The remaining registers are readable and writable outside low-power mode at all times, including while `op_active` is 1:
  - address 0: control register
  - address 2: test register 0
  - address 3: test register 1
  - address 4: test register 2
  - addresses 5 to 9: signature registers 0 to 4

  The control register also reads live while `lp_mode` is 1.
- R12: Address 1 is a read-only status word. Bit 0 is the `op_active` value at the commit edge, and bits 31:1 are zero. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, held for the two-cycle access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| lp_mode | input | 1 | Low-power mode active |
| op_active | input | 1 | Array operation in progress (status only) |
| rdata | output | 32 | Read data, valid with `ready` |
| ready | output | 1 | One-cycle completion pulse |

## Verification
A wrong access phase shows up within one access. `ready` appears a cycle early or late, appears twice, or appears after an abandoned window, and the per-access check of `ready` catches each case. A corrupted register or a write that leaked through the low-power lock stays silent until that register is next read. For that reason every write, locked write and unmapped write is followed by read-backs of the registers it could have touched. A wrong blocking mask appears on the very read that commits in low power, as live bits where zeros are expected, or zeros where live bits are expected.

// File: rtl/rau_pkg.sv
package rau_pkg;

    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 4;
    localparam int N_SIG          = 5;
    localparam logic [DATA_W-1:0] TST0_LP_MASK = 32'h0000_FFFF;

    // word map
    localparam int A_CTRL   = 0;
    localparam int A_STAT   = 1;
    localparam int A_TST0   = 2;
    localparam int A_TST1   = 3;
    localparam int A_TST2   = 4;
    localparam int A_SIG0   = 5;
    localparam int N_MAPPED = A_SIG0 + N_SIG;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [N_MAPPED-1:0][DATA_W-1:0] bank_t;

    typedef enum logic {
        PH_IDLE,
        PH_SECOND
    } phase_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t wdata;
        logic  lp;
    } cmd_t;

    function automatic logic is_mapped(addr_t a);
        return int'(a) < N_MAPPED;
    endfunction

    function automatic logic is_writable(addr_t a);
        return is_mapped(a) && (int'(a) != A_STAT);
    endfunction

    // bits hidden from reads while low power is active
    function automatic word_t lp_block_mask(addr_t a);
        word_t m;
        m = '0;
        if (int'(a) == A_TST0)
            m = TST0_LP_MASK;
        else if (int'(a) == A_TST1 || int'(a) == A_TST2)
            m = '1;
        else if (int'(a) >= A_SIG0 && int'(a) < N_MAPPED)
            m = '1;
        return m;
    endfunction

endpackage

// File: rtl/rau_seq.sv
module rau_seq
    import rau_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs,
    input  logic  we,
    input  addr_t addr,
    input  word_t wdata,
    input  logic  lp_mode,
    output logic  commit,
    output cmd_t  cmd
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   if (cs) phase_q <= PH_SECOND;
                PH_SECOND: phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // inputs are not held here: the commit edge sees them live
    assign commit = (phase_q == PH_SECOND) && cs;
    assign cmd    = '{we: we, addr: addr, wdata: wdata, lp: lp_mode};

endmodule

// File: rtl/rau_bank.sv
module rau_bank
    import rau_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  word_t wr_data,
    output bank_t regs_o
);

    logic [N_MAPPED-1:0] hit;
    bank_t               regs_q;

    for (genvar i = 0; i < N_MAPPED; i++) begin : g_hit
        if (i == A_STAT) begin : g_ro
            assign hit[i] = 1'b0;
        end else begin : g_rw
            assign hit[i] = wr_en && (int'(wr_addr) == i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < N_MAPPED; i++) begin
                if (hit[i]) regs_q[i] <= wr_data;
            end
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/rau_rdmux.sv
module rau_rdmux
    import rau_pkg::*;
(
    input  bank_t regs,
    input  addr_t addr,
    input  logic  lp,
    input  logic  op_active,
    output word_t data
);

    word_t raw;

    always_comb begin
        raw = '0;
        for (int i = 0; i < N_MAPPED; i++) begin
            if (int'(addr) == i) begin
                if (i == A_STAT) raw = word_t'(op_active);
                else             raw = regs[i];
            end
        end
    end

    assign data = lp ? (raw & ~lp_block_mask(addr)) : raw;

endmodule

// File: rtl/rau_top.sv
module rau_top
    import rau_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs,
    input  logic        we,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    input  logic        lp_mode,
    input  logic        op_active,
    output logic [31:0] rdata,
    output logic        ready
);

    logic  commit;
    cmd_t  cmd;
    bank_t regs;
    word_t rd_word;
    logic  wr_en;

    rau_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .lp_mode (lp_mode),
        .commit  (commit),
        .cmd     (cmd)
    );

    // all writes locked in low power; unmapped and read-only slots dropped
    assign wr_en = commit && cmd.we && !cmd.lp && is_writable(cmd.addr);

    rau_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (cmd.addr),
        .wr_data (cmd.wdata),
        .regs_o  (regs)
    );

    rau_rdmux u_rdmux (
        .regs      (regs),
        .addr      (cmd.addr),
        .lp        (cmd.lp),
        .op_active (op_active),
        .data      (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            rdata <= '0;
        end else begin
            ready <= commit;
            rdata <= (commit && !cmd.we) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/rau_chk.sv
module rau_chk
    import rau_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cs,
    input logic  we,
    input addr_t addr,
    input logic  lp_mode,
    input logic  ready,
    input word_t rdata,
    input bank_t regs
);

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R4
    ready_cs_window_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> ($past(cs, 1) && $past(cs, 2)));

    // R5
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rdata == '0));

    // R6
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !$past(we) && !is_mapped($past(addr))) |-> (rdata == '0));

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(we) && !is_mapped($past(addr))) |-> (regs == $past(regs)));

    // R8
    lp_write_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(we) && $past(lp_mode)) |-> (regs == $past(regs)));

    // R9
    lp_read_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !$past(we) && $past(lp_mode)) |->
            ((rdata & lp_block_mask($past(addr))) == '0));

endmodule

bind rau_top rau_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .we      (we),
    .addr    (addr),
    .lp_mode (lp_mode),
    .ready   (ready),
    .rdata   (rdata),
    .regs    (regs)
);

// File: tb/tb_rau_top.sv
`timescale 1ns/1ps
module tb_rau_top;
    import rau_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, we = 1'b0, lp_mode = 1'b0, op_active = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    word_t model [N_MAPPED];
    word_t exp_q [$];
    string tag_q [$];

    rau_top dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input word_t act, input word_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expectation from the requirement text
    function automatic word_t exp_read(input int a, input bit lp);
        word_t v;
        if (a >= N_MAPPED) return '0;
        v = (a == 1) ? word_t'(op_active) : model[a];
        if (lp) begin
            if (a >= 3) v = '0;
            else if (a == 2) v = v & 32'hFFFF_0000;
        end
        return v;
    endfunction

    // monitor: compare every ready pulse with the scoreboard head
    always @(negedge clk) begin
        if (!rst && ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected ready", rdata, '0);
            end else begin
                automatic word_t e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rdata == e, t, rdata, e);
            end
        end
    end

    // full two-cycle access; first-edge values may differ (R3)
    task automatic access(input bit w0, input int a0, input word_t d0,
                          input bit w1, input int a1, input word_t d1,
                          input bit lp, input string tag);
        word_t e;
        e = w1 ? '0 : exp_read(a1, lp);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cs = 1'b1; we = w0; addr = addr_t'(a0); wdata = d0; lp_mode = lp;
        @(negedge clk);
        we = w1; addr = addr_t'(a1); wdata = d1;
        @(negedge clk);
        chk(ready == 1'b1, {"R2 ready after commit: ", tag}, word_t'(ready), 32'd1);
        cs = 1'b0; we = 1'b0; lp_mode = 1'b0;
        if (w1 && !lp && a1 < N_MAPPED && a1 != 1) model[a1] = d1;
        @(negedge clk);
        chk(ready == 1'b0, {"R2 single pulse: ", tag}, word_t'(ready), 32'd0);
    endtask

    task automatic wr(input int a, input word_t d, input bit lp, input string tag);
        access(1'b1, a, d, 1'b1, a, d, lp, tag);
    endtask

    task automatic rd(input int a, input bit lp, input string tag);
        access(1'b0, a, '0, 1'b0, a, '0, lp, tag);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N_MAPPED; i++) rd(i, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < N_MAPPED; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(ready == 1'b0, "R1 ready after reset", word_t'(ready), '0);
        chk(rdata == '0, "R1 rdata after reset", rdata, '0);
        check_all("R1 reset contents");

        // R5 / R11 basic write and read-back
        wr(0, 32'hA5A5_0001, 1'b0, "R5 write ctrl");
        wr(2, 32'h1234_5678, 1'b0, "R11 write tst0");
        wr(3, 32'hCAFE_0003, 1'b0, "R11 write tst1");
        wr(4, 32'hBEEF_0004, 1'b0, "R11 write tst2");
        for (int i = 5; i < N_MAPPED; i++) wr(i, 32'h5100_0000 + 32'(i), 1'b0, "R11 write sig");
        check_all("R5 read-back");

        // R12 status word
        wr(1, 32'hFFFF_FFFF, 1'b0, "R12 write status");
        rd(1, 1'b0, "R12 status idle");
        op_active = 1'b1;
        rd(1, 1'b0, "R12 status busy");
        rd(7, 1'b0, "R11 sig2 during array op");
        rd(0, 1'b0, "R11 ctrl during array op");
        op_active = 1'b0;

        // R6 / R7 unmapped
        for (int a = N_MAPPED; a < 16; a++) rd(a, 1'b0, "R6 unmapped read");
        wr(12, 32'hDEAD_DEAD, 1'b0, "R7 unmapped write");
        wr(15, 32'hFFFF_FFFF, 1'b0, "R7 unmapped write");
        check_all("R7 after unmapped write");

        // R3 first-edge values ignored
        access(1'b1, 0, 32'h0BAD_0BAD, 1'b1, 3, 32'h3333_0033, 1'b0, "R3 write second-edge");
        rd(0, 1'b0, "R3 ctrl untouched");
        rd(3, 1'b0, "R3 tst1 took second data");
        access(1'b1, 4, 32'h0BAD_0BAD, 1'b0, 5, '0, 1'b0, "R3 read second-edge");
        rd(4, 1'b0, "R3 tst2 untouched");

        // R4 abandoned access
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 4'd0; wdata = 32'h7777_7777;
        @(negedge clk);
        cs = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R4 no ready after abandon", word_t'(ready), '0);
        @(negedge clk);
        chk(ready == 1'b0, "R4 no late ready", word_t'(ready), '0);
        we = 1'b0;
        rd(0, 1'b0, "R4 ctrl unchanged");

        // R8 write lock in low power
        wr(0, 32'h8888_8888, 1'b1, "R8 lp write ctrl");
        wr(6, 32'h8888_8888, 1'b1, "R8 lp write sig1");
        check_all("R8 after lp writes");

        // R9 / R10 / R11 low-power reads
        for (int a = 3; a < N_MAPPED; a++) rd(a, 1'b1, "R9 lp blocked read");
        rd(2, 1'b1, "R10 lp tst0 partial");
        rd(0, 1'b1, "R11 lp ctrl live");
        rd(1, 1'b1, "R12 lp status live");
        rd(5, 1'b0, "R11 sig0 live after lp");
        rd(2, 1'b0, "R11 tst0 full after lp");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all accesses completed", word_t'(exp_q.size()), '0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule